// File: doc/BRIEF.md
# Ethernet Station Address Hash Filter

This block holds the station address of an Ethernet receive path and derives from it two filter structures. One is an exact copy of the 48-bit address, packed into two 32-bit physical-address words. The other is a 64-bit individual-address hash table in which exactly one bit is set. The table is split across an upper and a lower 32-bit word. The bit is chosen by a six-bit index taken from a reflected CRC-32 over the address. That CRC is computed serially, one address bit per clock.

A lookup port takes a received destination address and runs the same serial CRC over it. When the CRC finishes, the port reports two results. An exact match means all 48 bits equal the stored station address. A hash hit means the table bit selected by the destination's index is set. Software or a parser loads the station address once through the configuration port and then issues one lookup per received frame.

Address byte 0 is the first byte on the wire and sits in bits 47:40 of every 48-bit address port. Byte 5 sits in bits 7:0.

Top module: `uhf_top`

## Requirements
- R1: After reset, both hash words read zero, phys_word0 reads 0x00000000, phys_word1 reads 0x00008808, both busy flags are low and the stored station address is zero.
- R2: A cfg_valid pulse accepted while cfg_busy is low stores the address at that clock edge. phys_word0 then holds bytes 0..3 with byte 0 in bits 31:24. phys_word1 holds byte 4 in bits 31:24, byte 5 in bits 23:16 and the constant 0x8808 in bits 15:0.
- R3: Accepting a configuration raises cfg_busy on the accepting edge, and it stays high for 48 clock edges.
- R4: cfg_done is high for exactly one cycle, the cycle after the 48th edge, and cfg_busy is low in that cycle.
- R5: The hash index is bits 31:26 of a CRC register. The register starts at 0xFFFFFFFF and then takes 48 steps, over bytes 0 to 5 in order and each byte from bit 0 up. At each step, if the data bit XOR the CRC's bit 0 is 1, the CRC becomes (crc >> 1) ^ 0xEDB88320. Otherwise it becomes crc >> 1.
- R6: One edge after cfg_done, an index of 32 or more sets bit (index-32) of hash_hi and clears hash_lo. A smaller index sets bit index of hash_lo and clears hash_hi.
- R7: A cfg_valid pulse that arrives while cfg_busy is high is ignored. The physical words and the hash from the earlier configuration are left as they were.
- R8: A lookup is accepted on an edge where lk_valid is high and lk_busy is low. lk_busy is then high for 48 edges, and lk_done is high for one cycle after the 48th edge.
- R9: During lk_done, lk_match is 1 exactly when the destination equals the stored station address. lk_hit is 1 exactly when table bit index_of(destination) is set, where bits 63:32 are hash_hi and bits 31:0 are hash_lo.
- R10: An lk_valid pulse that arrives while lk_busy is high is ignored. The running lookup finishes with results for its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Load a new station address |
| cfg_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| cfg_busy | output | 1 | Station hash computation in progress |
| cfg_done | output | 1 | One-cycle pulse when the station hash index is ready |
| phys_word0 | output | 32 | Station bytes 0..3 |
| phys_word1 | output | 32 | Station bytes 4..5 and 0x8808 |
| hash_hi | output | 32 | Hash table bits 63:32 |
| hash_lo | output | 32 | Hash table bits 31:0 |
| lk_valid | input | 1 | Start a lookup |
| lk_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | One-cycle pulse, lookup results valid |
| lk_hit | output | 1 | Hash table hit, valid with lk_done |
| lk_match | output | 1 | Exact station match, valid with lk_done |

## Verification
The physical words and the busy flags change on the accepting edge itself. A done pulse is due after the 48th following edge, and the hash words one edge later still. The bench drives every input on the falling edge. It counts rising edges from the accepting edge and samples on the falling edge that follows each expected change. It also checks busy one edge early, so a late or early done is reported. Expected indices come from a bench model of the CRC steps in R5. The bench uses that model to search for addresses whose index lands in each half of the table.

// File: rtl/uhf_pkg.sv
package uhf_pkg;
  localparam int ADDR_W   = 48;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = ADDR_W / BYTE_W;
  localparam int CRC_W    = 32;
  localparam int IDX_W    = 6;
  localparam int WORD_W   = 32;
  localparam int TBL_W    = 2 * WORD_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;
  localparam logic [15:0]      PHYS_TAG = 16'h8808;
endpackage

// File: rtl/uhf_rst_sync.sv
module uhf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/uhf_crc_serial.sv
module uhf_crc_serial
  import uhf_pkg::*;
#(
  parameter int DATA_W = ADDR_W,
  parameter int OUT_W  = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  index
);
  localparam int NB    = DATA_W / BYTE_W;
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  // Reorder so serial bit k sits at position k: byte 0 (top byte) first, LSB first.
  logic [DATA_W-1:0] wire_order;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign wire_order[b*BYTE_W + i] = data[(NB-1-b)*BYTE_W + i];
    end
  end

  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d, done_q, done_d;
  logic              fb;

  always_comb begin
    crc_d  = crc_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    fb     = sh_q[0] ^ crc_q[0];
    if (busy_q) begin
      crc_d = fb ? ((crc_q >> 1) ^ CRC_POLY) : (crc_q >> 1);
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      crc_d  = CRC_SEED;
      sh_d   = wire_order;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign index = crc_q[CRC_W-1 -: OUT_W];

  a_r3_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/uhf_station_regs.sv
module uhf_station_regs
  import uhf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hash_we,
  input  logic [IDX_W-1:0]  hash_idx,
  output logic [ADDR_W-1:0] station,
  output logic [WORD_W-1:0] phys_word0,
  output logic [WORD_W-1:0] phys_word1,
  output logic [WORD_W-1:0] hash_hi,
  output logic [WORD_W-1:0] hash_lo
);
  localparam int SEL_W = $clog2(WORD_W);

  logic [ADDR_W-1:0] station_q, station_d;
  logic [WORD_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [WORD_W-1:0] one_hot;

  always_comb begin
    one_hot   = WORD_W'(1) << hash_idx[SEL_W-1:0];
    station_d = load ? addr : station_q;
    hi_d      = hi_q;
    lo_d      = lo_q;
    if (hash_we) begin
      hi_d = hash_idx[IDX_W-1] ? one_hot : '0;
      lo_d = hash_idx[IDX_W-1] ? '0 : one_hot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      station_q <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
    end else begin
      station_q <= station_d;
      hi_q      <= hi_d;
      lo_q      <= lo_d;
    end
  end

  assign station    = station_q;
  assign phys_word0 = station_q[ADDR_W-1 -: WORD_W];
  assign phys_word1 = {station_q[ADDR_W-WORD_W-1:0], PHYS_TAG};
  assign hash_hi    = hi_q;
  assign hash_lo    = lo_q;

  a_r6_one_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    hash_we |=> ($countones({hash_hi, hash_lo}) == 1));
  a_r6_table_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hash_hi, hash_lo}));
  a_r2_load_phys0: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phys_word0 == $past(addr[ADDR_W-1 -: WORD_W])));
endmodule

// File: rtl/uhf_top.sv
module uhf_top
  import uhf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [47:0] cfg_addr,
  output logic        cfg_busy,
  output logic        cfg_done,
  output logic [31:0] phys_word0,
  output logic [31:0] phys_word1,
  output logic [31:0] hash_hi,
  output logic [31:0] hash_lo,
  input  logic        lk_valid,
  input  logic [47:0] lk_addr,
  output logic        lk_busy,
  output logic        lk_done,
  output logic        lk_hit,
  output logic        lk_match
);
  logic              rst_n_s;
  logic              cfg_load, lk_load;
  logic [IDX_W-1:0]  cfg_idx, lk_idx;
  logic [ADDR_W-1:0] station;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [TBL_W-1:0]  table_bits;

  uhf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign cfg_load = cfg_valid && !cfg_busy;
  assign lk_load  = lk_valid && !lk_busy;

  uhf_crc_serial #(.DATA_W(ADDR_W), .OUT_W(IDX_W)) u_cfg_crc (
    .clk(clk), .rst_n(rst_n_s), .start(cfg_load), .data(cfg_addr),
    .busy(cfg_busy), .done(cfg_done), .index(cfg_idx));

  uhf_station_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .load(cfg_load), .addr(cfg_addr),
    .hash_we(cfg_done), .hash_idx(cfg_idx), .station(station),
    .phys_word0(phys_word0), .phys_word1(phys_word1),
    .hash_hi(hash_hi), .hash_lo(hash_lo));

  uhf_crc_serial #(.DATA_W(ADDR_W), .OUT_W(IDX_W)) u_lk_crc (
    .clk(clk), .rst_n(rst_n_s), .start(lk_load), .data(lk_addr),
    .busy(lk_busy), .done(lk_done), .index(lk_idx));

  always_comb dest_d = lk_load ? lk_addr : dest_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) dest_q <= '0;
    else          dest_q <= dest_d;
  end

  assign table_bits = {hash_hi, hash_lo};
  assign lk_hit     = lk_done && table_bits[lk_idx];
  assign lk_match   = lk_done && (dest_q == station);

  a_r7_busy_holds_phys: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_busy |=> $stable(phys_word0) && $stable(phys_word1));
  a_r10_busy_holds_dest: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_busy |=> $stable(dest_q));
  a_r9_results_only_when_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_done |-> !(lk_hit || lk_match));
endmodule

// File: tb/test_uhf_top.sv
module test_uhf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [47:0] cfg_addr = '0;
  logic        cfg_busy, cfg_done;
  logic [31:0] phys_word0, phys_word1, hash_hi, hash_lo;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic        lk_busy, lk_done, lk_hit, lk_match;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uhf_top i_uhf_top (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_busy(cfg_busy), .cfg_done(cfg_done), .phys_word0(phys_word0),
    .phys_word1(phys_word1), .hash_hi(hash_hi), .hash_lo(hash_lo),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_busy(lk_busy),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_match(lk_match));

  localparam logic [47:0] VEC [8] = '{
    48'h0011_2233_4455, 48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 48'h0250_C2A1_B3C4,
    48'h8000_0000_0000, 48'hDEAD_BEEF_0102, 48'h1234_5678_9ABC, 48'hA5A5_5A5A_C3C3};

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by = a[47-8*b -: 8];
      for (int i = 0; i < 8; i++)
        c = (by[i] ^ c[0]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic [63:0] ref_tbl(input logic [47:0] a);
    return 64'd1 << ref_idx(a);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Configure and check physical words, busy, done and the hash words.
  task automatic do_cfg(input logic [47:0] a);
    @(negedge clk); cfg_valid = 1'b1; cfg_addr = a;
    @(posedge clk);
    @(negedge clk); cfg_valid = 1'b0;
    check("R2 phys_word0", phys_word0, a[47:16]);
    check("R2 phys_word1", phys_word1, {a[15:0], 16'h8808});
    check("R3 busy raised", cfg_busy, 1'b1);
    repeat (47) @(posedge clk);
    @(negedge clk);
    check("R3 busy at edge 47", {cfg_busy, cfg_done}, 2'b10);
    @(posedge clk); @(negedge clk);
    check("R4 done after edge 48", {cfg_busy, cfg_done}, 2'b01);
    @(posedge clk); @(negedge clk);
    check("R4 done single", cfg_done, 1'b0);
    check("R5 R6 hash table", {hash_hi, hash_lo}, ref_tbl(a));
  endtask

  task automatic do_lk(input logic [47:0] a, input logic exp_m, input logic exp_h, input string tag);
    @(negedge clk); lk_valid = 1'b1; lk_addr = a;
    @(posedge clk);
    @(negedge clk); lk_valid = 1'b0;
    check("R8 lk_busy raised", lk_busy, 1'b1);
    repeat (48) @(posedge clk);
    @(negedge clk);
    check("R8 lk_done", {lk_busy, lk_done}, 2'b01);
    check({"R9 ", tag}, {lk_match, lk_hit}, {exp_m, exp_h});
    @(posedge clk); @(negedge clk);
    check("R8 lk_done single", lk_done, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [47:0] lo_a, hi_a, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hash", {hash_hi, hash_lo}, 64'd0);
    check("R1 phys0", phys_word0, 32'h0);
    check("R1 phys1", phys_word1, 32'h0000_8808);
    check("R1 busy", {cfg_busy, lk_busy, cfg_done, lk_done}, 4'b0);
    // R1: empty table, station zero matches address zero, hit is 0
    do_lk(48'h0, 1'b1, 1'b0, "R1 zero station");

    // Vector table walk
    foreach (VEC[k]) begin
      do_cfg(VEC[k]);
      do_lk(VEC[k], 1'b1, 1'b1, "own address");
      s = VEC[(k+1) % 8];
      do_lk(s, 1'b0, ref_idx(s) == ref_idx(VEC[k]), "other address");
    end

    // R6: addresses landing in each half of the table
    lo_a = 48'h0; hi_a = 48'h0;
    for (int n = 1; n < 200; n++) begin
      if (ref_idx(48'(n)) < 6'd32 && lo_a == 48'h0) lo_a = 48'(n);
      if (ref_idx(48'(n)) >= 6'd32 && hi_a == 48'h0) hi_a = 48'(n);
    end
    do_cfg(hi_a);
    check("R6 upper half lo clear", hash_lo, 32'h0);
    check("R6 upper half bit", hash_hi, 32'd1 << (ref_idx(hi_a) - 6'd32));
    do_cfg(lo_a);
    check("R6 lower half hi clear", hash_hi, 32'h0);
    check("R6 lower half bit", hash_lo, 32'd1 << ref_idx(lo_a));

    // R7: cfg_valid while busy is ignored
    do_cfg(48'h0102_0304_0506);
    @(negedge clk); cfg_valid = 1'b1; cfg_addr = 48'hAAAA_BBBB_CCCC;
    @(posedge clk); @(negedge clk); cfg_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk); cfg_valid = 1'b1; cfg_addr = 48'h1111_2222_3333;
    @(posedge clk); @(negedge clk); cfg_valid = 1'b0;
    check("R7 phys0 unchanged", phys_word0, 32'hAAAA_BBBB);
    check("R7 phys1 unchanged", phys_word1, 32'hCCCC_8808);
    repeat (60) @(posedge clk);
    @(negedge clk);
    check("R7 hash from accepted cfg", {hash_hi, hash_lo}, ref_tbl(48'hAAAA_BBBB_CCCC));

    // R10: lk_valid while busy is ignored
    @(negedge clk); lk_valid = 1'b1; lk_addr = 48'hAAAA_BBBB_CCCC;
    @(posedge clk); @(negedge clk); lk_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); lk_valid = 1'b1; lk_addr = 48'h0000_0000_0007;
    @(posedge clk); @(negedge clk); lk_valid = 1'b0;
    repeat (42) @(posedge clk);
    @(negedge clk);
    check("R10 lk_done timing", {lk_busy, lk_done}, 2'b01);
    check("R10 results of first lookup", {lk_match, lk_hit}, 2'b11);
    @(posedge clk); @(negedge clk);
    check("R10 no second done", {lk_busy, lk_done}, 2'b00);

    finish_run();
  end
endmodule